// File: doc/BRIEF.md
# Raster Position Counter with Window Strobes

This block tracks where an image sensor readout currently is. A pixel counter advances once per master clock and returns to zero on each rising edge of the horizontal sync input. A line counter advances on each horizontal sync edge and returns to zero on each rising edge of the vertical sync input. The pixel count is compared against programmable pixel windows. These produce a horizontal-blanking strobe, a pixel-blanking strobe and a black-level clamp strobe.

The clamp strobe and the pixel-blanking strobe leave the block on one shared output, picked by a select input. A mode input decides what the pixel counter does once it reaches its last code. It can roll over to zero, or it can stay at the last code until the next horizontal sync. The second choice supports lines longer than the counter range: the counter stays put, so no window strobe can change past the last code, while the sample clocking elsewhere keeps running. A sticky flag records any pixel or line overflow until the next vertical sync.

Top module: `raster_pos_gen`

## Requirements
- R1: A rising edge on `hd_in` (sampled 1 on a clock edge after being sampled 0) sets `pixel_count` to 0 at that edge. On every other clock edge out of reset, `pixel_count` increases by one, subject to R2 and R3.
- R2: With `hold_mode` = 0, `pixel_count` goes from 4095 to 0 on the next edge and keeps counting.
- R3: With `hold_mode` = 1, `pixel_count` stays at 4095 on every edge until the next `hd_in` rising edge.
- R4: `line_count` increases by one on each `hd_in` rising edge and stays at 4095 once there.
- R5: A rising edge on `vd_in` sets `line_count` to 0. This takes precedence over a horizontal edge in the same cycle and leaves `pixel_count` untouched.
- R6: `hblank_out` is 1 exactly while `hblank_start` ≤ `pixel_count` < `hblank_end`, and `pblank` behaves the same way with its own bounds. Both follow `pixel_count` in the same cycle. A window whose start is not below its end never asserts.
- R7: The clamp strobe is 1 while `clamp_start` ≤ `pixel_count` < `clamp_start` + L. L is `clamp_width` bounded to the range 2 to 20, and the sum does not wrap past 4095.
- R8: `shared_out` carries the clamp strobe when `share_sel` = 1 and the pixel-blanking strobe when `share_sel` = 0.
- R9: In hold mode, while `pixel_count` rests at 4095 and the configuration is unchanged, neither `hblank_out` nor `shared_out` changes.
- R10: `overflow` becomes 1 at the edge where the pixel counter passes 4095 (rolls over or holds). It also becomes 1 at the edge where a horizontal edge finds `line_count` at 4095. A `vd_in` rising edge clears it, with precedence over a new overflow.
- R11: The synchronous active-low reset `rst_n` sets `pixel_count`, `line_count` and `overflow` to 0. While reset is held, the counters do not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hd_in | input | 1 | Horizontal sync, rising edge active, synchronous to clk |
| vd_in | input | 1 | Vertical sync, rising edge active, synchronous to clk |
| hold_mode | input | 1 | 1: pixel counter holds at last code; 0: wraps |
| share_sel | input | 1 | 1: clamp on shared_out; 0: pixel blanking |
| hblank_start | input | 12 | First pixel of horizontal blanking |
| hblank_end | input | 12 | Pixel after the last one of horizontal blanking |
| pblank_start | input | 12 | First pixel of pixel blanking |
| pblank_end | input | 12 | Pixel after the last one of pixel blanking |
| clamp_start | input | 12 | First pixel of the clamp strobe |
| clamp_width | input | 5 | Requested clamp length, bounded to 2..20 |
| pixel_count | output | 12 | Current pixel position |
| line_count | output | 12 | Current line position |
| hblank_out | output | 1 | Horizontal-blanking strobe |
| shared_out | output | 1 | Clamp or pixel-blanking strobe |
| overflow | output | 1 | Sticky pixel/line overflow flag |

## Verification
The hardest states to reach are the ones at the end of the counter range: a pixel counter resting at 4095 in hold mode, and a line counter saturated at 4095. Each needs thousands of cycles with no sync edge, or thousands of sync edges. The stimulus lets the pixel counter run a full 4096 clocks after one horizontal edge, once in each mode. It then issues more than 4095 short horizontal pulses with no vertical pulse, so the line counter saturates and the sticky flag sets. Both cases are then released with a vertical pulse.

// File: rtl/rpt_pkg.sv
// Shared definitions for the raster position counter.
// Assumes: nothing beyond the language; holds only types and indices.
package rpt_pkg;
    typedef enum logic {MODE_WRAP = 1'b0, MODE_HOLD = 1'b1} ovf_mode_e;
    localparam int WIN_HBLK = 0;
    localparam int WIN_PBLK = 1;
    localparam int WIN_CLMP = 2;
    localparam int NUM_WIN  = 3;
endpackage

// File: rtl/rpt_edge_det.sv
// Rising-edge detector for a bundle of sync levels.
// Assumes: inputs are already synchronous to clk; an input high at reset
// release counts as a rising edge.
module rpt_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;

    // remember the previous level of every input
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/rpt_pixel_ctr.sv
// Pixel position counter: restarts on a horizontal edge, otherwise counts,
// and at its last code either wraps or holds depending on hold_en.
// Assumes: restart is a one-cycle pulse from the edge detector.
module rpt_pixel_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          hold_en,
    output logic [CW-1:0] count,
    output logic          over_evt
);
    localparam logic [CW-1:0] LAST = '1;
    logic at_last;

    assign at_last  = (count == LAST);
    assign over_evt = at_last && !restart;

    // advance, restart or hold the pixel position
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (restart)          count <= '0;
        else if (at_last && hold_en) count <= count;
        else                       count <= count + 1'b1;
    end

    // R1
    pix_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> count == '0);
    // R1
    pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && count != LAST) |=> count == $past(count) + 1'b1);
    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !hold_en && count == LAST) |=> count == '0);
    // R3
    pix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && hold_en && count == LAST) |=> count == LAST);
endmodule

// File: rtl/rpt_line_ctr.sv
// Line position counter: steps on each horizontal edge, saturates at its
// last code, and clears on a vertical edge (vertical wins).
// Assumes: line_adv and frame_start are one-cycle pulses.
module rpt_line_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_adv,
    input  logic          frame_start,
    output logic [CW-1:0] count,
    output logic          over_evt
);
    localparam logic [CW-1:0] LAST = '1;
    logic at_last;

    assign at_last  = (count == LAST);
    assign over_evt = at_last && line_adv && !frame_start;

    // clear on frame start, step on line start, stick at the last code
    always_ff @(posedge clk) begin
        if (!rst_n)                     count <= '0;
        else if (frame_start)           count <= '0;
        else if (line_adv && !at_last)  count <= count + 1'b1;
    end

    // R5
    line_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> count == '0);
    // R4
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_adv && !frame_start && !at_last) |=> count == $past(count) + 1'b1);
    // R4
    line_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_last && !frame_start) |=> count == LAST);
endmodule

// File: rtl/rpt_window.sv
// Half-open window comparator: hit while lo <= pos < hi.
// Assumes: all operands share one width wide enough that hi cannot wrap.
module rpt_window #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pos,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output logic         hit
);
    assign hit = (pos >= lo) && (pos < hi);

    // R6
    win_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo >= hi) |-> !hit);
endmodule

// File: rtl/raster_pos_gen.sv
// Top level: sync edge detection, pixel and line counters, three window
// comparators, shared clamp/blank output and a sticky overflow flag.
// Assumes: hd_in and vd_in are synchronous to clk; configuration inputs
// are quasi-static during a line.
module raster_pos_gen #(
    parameter int CW        = 12,
    parameter int WID_W     = 5,
    parameter int CLAMP_MIN = 2,
    parameter int CLAMP_MAX = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hd_in,
    input  logic             vd_in,
    input  logic             hold_mode,
    input  logic             share_sel,
    input  logic [CW-1:0]    hblank_start,
    input  logic [CW-1:0]    hblank_end,
    input  logic [CW-1:0]    pblank_start,
    input  logic [CW-1:0]    pblank_end,
    input  logic [CW-1:0]    clamp_start,
    input  logic [WID_W-1:0] clamp_width,
    output logic [CW-1:0]    pixel_count,
    output logic [CW-1:0]    line_count,
    output logic             hblank_out,
    output logic             shared_out,
    output logic             overflow
);
    import rpt_pkg::*;

    localparam int EW = CW + 1;
    localparam logic [CW-1:0] LAST = '1;

    logic [1:0]  sync_rise;
    logic        hd_rise, vd_rise;
    logic        pix_over, line_over;
    ovf_mode_e   mode;
    logic [EW-1:0] clamp_len;
    logic [EW-1:0] win_lo [NUM_WIN];
    logic [EW-1:0] win_hi [NUM_WIN];
    logic [NUM_WIN-1:0] win_hit;

    assign mode = ovf_mode_e'(hold_mode);

    rpt_edge_det #(.N(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .lvl({vd_in, hd_in}), .rise(sync_rise)
    );
    assign hd_rise = sync_rise[0];
    assign vd_rise = sync_rise[1];

    rpt_pixel_ctr #(.CW(CW)) u_pix (
        .clk(clk), .rst_n(rst_n), .restart(hd_rise),
        .hold_en(mode == MODE_HOLD), .count(pixel_count), .over_evt(pix_over)
    );

    rpt_line_ctr #(.CW(CW)) u_line (
        .clk(clk), .rst_n(rst_n), .line_adv(hd_rise),
        .frame_start(vd_rise), .count(line_count), .over_evt(line_over)
    );

    // bound the requested clamp length to the legal pulse range
    always_comb begin
        if (int'(clamp_width) < CLAMP_MIN)      clamp_len = EW'(CLAMP_MIN);
        else if (int'(clamp_width) > CLAMP_MAX) clamp_len = EW'(CLAMP_MAX);
        else                                    clamp_len = EW'(clamp_width);
    end

    // assemble the window bounds one bit wider than the counter
    always_comb begin
        win_lo[WIN_HBLK] = {1'b0, hblank_start};
        win_hi[WIN_HBLK] = {1'b0, hblank_end};
        win_lo[WIN_PBLK] = {1'b0, pblank_start};
        win_hi[WIN_PBLK] = {1'b0, pblank_end};
        win_lo[WIN_CLMP] = {1'b0, clamp_start};
        win_hi[WIN_CLMP] = {1'b0, clamp_start} + clamp_len;
    end

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        rpt_window #(.W(EW)) u_win (
            .clk(clk), .rst_n(rst_n), .pos({1'b0, pixel_count}),
            .lo(win_lo[g]), .hi(win_hi[g]), .hit(win_hit[g])
        );
    end

    assign hblank_out = win_hit[WIN_HBLK];
    assign shared_out = share_sel ? win_hit[WIN_CLMP] : win_hit[WIN_PBLK];

    // sticky overflow flag, cleared by the frame edge
    always_ff @(posedge clk) begin
        if (!rst_n)                     overflow <= 1'b0;
        else if (vd_rise)               overflow <= 1'b0;
        else if (pix_over || line_over) overflow <= 1'b1;
    end

    // R10
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vd_rise |=> !overflow);
    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pix_over || line_over) && !vd_rise) |=> overflow);
    // R9
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_mode && pixel_count == LAST && $past(pixel_count) == LAST
         && $stable({share_sel, hblank_start, hblank_end, pblank_start,
                     pblank_end, clamp_start, clamp_width}))
        |-> $stable({hblank_out, shared_out}));
endmodule

// File: tb/tb_raster_pos_gen.sv
module tb_raster_pos_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hd_in = 1'b0, vd_in = 1'b0, hold_mode = 1'b0, share_sel = 1'b0;
    logic [11:0] hblank_start = '0, hblank_end = '0;
    logic [11:0] pblank_start = '0, pblank_end = '0, clamp_start = '0;
    logic [4:0]  clamp_width = '0;
    logic [11:0] pixel_count, line_count;
    logic        hblank_out, shared_out, overflow;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_pos_gen dut (
        .clk(clk), .rst_n(rst_n), .hd_in(hd_in), .vd_in(vd_in),
        .hold_mode(hold_mode), .share_sel(share_sel),
        .hblank_start(hblank_start), .hblank_end(hblank_end),
        .pblank_start(pblank_start), .pblank_end(pblank_end),
        .clamp_start(clamp_start), .clamp_width(clamp_width),
        .pixel_count(pixel_count), .line_count(line_count),
        .hblank_out(hblank_out), .shared_out(shared_out), .overflow(overflow)
    );

    // kind: 0 horizontal blank, 1 pixel blank, 2 clamp (b is the width)
    typedef struct packed {
        logic [1:0]  kind;
        logic [11:0] a;
        logic [11:0] b;
        logic [11:0] probe;
        logic        exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 12'd10, 12'd20, 12'd9,  1'b0},
        '{2'd0, 12'd10, 12'd20, 12'd10, 1'b1},
        '{2'd0, 12'd10, 12'd20, 12'd19, 1'b1},
        '{2'd0, 12'd10, 12'd20, 12'd20, 1'b0},
        '{2'd0, 12'd15, 12'd15, 12'd15, 1'b0},
        '{2'd0, 12'd30, 12'd20, 12'd25, 1'b0},
        '{2'd1, 12'd5,  12'd8,  12'd5,  1'b1},
        '{2'd1, 12'd5,  12'd8,  12'd8,  1'b0},
        '{2'd2, 12'd40, 12'd1,  12'd41, 1'b1},
        '{2'd2, 12'd40, 12'd1,  12'd42, 1'b0},
        '{2'd2, 12'd40, 12'd0,  12'd41, 1'b1},
        '{2'd2, 12'd40, 12'd25, 12'd59, 1'b1},
        '{2'd2, 12'd40, 12'd25, 12'd60, 1'b0},
        '{2'd2, 12'd40, 12'd7,  12'd46, 1'b1},
        '{2'd2, 12'd40, 12'd7,  12'd47, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hd_pulse();
        @(negedge clk) hd_in = 1'b1;
        @(negedge clk) hd_in = 1'b0;
    endtask

    task automatic vd_pulse();
        @(negedge clk) vd_in = 1'b1;
        @(negedge clk) vd_in = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_windows();
        hblank_start = '0; hblank_end = '0;
        pblank_start = '0; pblank_end = '0;
        clamp_start = 12'd4000; clamp_width = 5'd2;
    endtask

    initial begin
        clear_windows();
        // R11: reset state
        wait_cyc(4);
        check("R11 pixel in reset", pixel_count, 0);
        check("R11 line in reset", line_count, 0);
        check("R11 overflow in reset", overflow, 0);
        check("R6 hblank idle", hblank_out, 0);
        rst_n = 1'b1;
        wait_cyc(5);
        check("R1 free count after reset", pixel_count, 5);

        // R6 R7 R8: window table
        for (int i = 0; i < NV; i++) begin
            clear_windows();
            share_sel = (VEC[i].kind == 2'd2);
            case (VEC[i].kind)
                2'd0: begin hblank_start = VEC[i].a; hblank_end = VEC[i].b; end
                2'd1: begin pblank_start = VEC[i].a; pblank_end = VEC[i].b; end
                default: begin clamp_start = VEC[i].a; clamp_width = VEC[i].b[4:0]; end
            endcase
            hd_pulse();
            wait_cyc(VEC[i].probe);
            check("R1 count at probe", pixel_count, VEC[i].probe);
            if (VEC[i].kind == 2'd0) check("R6 hblank window", hblank_out, VEC[i].exp);
            else if (VEC[i].kind == 2'd1) check("R6 pblank window", shared_out, VEC[i].exp);
            else check("R7 clamp window", shared_out, VEC[i].exp);
        end

        // R8: select picks the source of the shared output
        clear_windows();
        clamp_start = 12'd40; clamp_width = 5'd7;
        share_sel = 1'b0;
        hd_pulse();
        wait_cyc(42);
        check("R8 pblank selected", shared_out, 0);
        share_sel = 1'b1;
        #1 check("R8 clamp selected", shared_out, 1);

        // R4 R5: line stepping, vertical clear, pixel untouched
        vd_pulse();
        check("R5 line cleared", line_count, 0);
        hd_pulse(); hd_pulse(); hd_pulse();
        check("R4 three lines", line_count, 3);
        wait_cyc(10);
        vd_pulse();
        check("R5 line cleared by vd", line_count, 0);
        check("R5 pixel unaffected by vd", pixel_count, 12);
        hd_pulse();
        @(negedge clk) begin hd_in = 1'b1; vd_in = 1'b1; end
        @(negedge clk) begin hd_in = 1'b0; vd_in = 1'b0; end
        check("R5 vd wins over hd", line_count, 0);
        check("R1 pixel restarted", pixel_count, 0);

        // R2 R10: wrap mode
        hold_mode = 1'b0;
        hd_pulse();
        wait_cyc(4095);
        check("R2 at last code", pixel_count, 4095);
        check("R10 no overflow yet", overflow, 0);
        wait_cyc(1);
        check("R2 wrapped", pixel_count, 0);
        check("R10 overflow after wrap", overflow, 1);
        wait_cyc(3);
        check("R2 keeps counting", pixel_count, 3);
        vd_pulse();
        check("R10 cleared by vd", overflow, 0);

        // R3 R9 R10: hold mode
        hold_mode = 1'b1;
        clear_windows();
        hblank_start = 12'd4000; hblank_end = 12'd4095;
        clamp_start = 12'd4090; clamp_width = 5'd10;
        share_sel = 1'b1;
        hd_pulse();
        wait_cyc(4094);
        check("R9 hblank before end", hblank_out, 1);
        wait_cyc(1);
        check("R3 reached last", pixel_count, 4095);
        check("R9 hblank off at last", hblank_out, 0);
        check("R9 clamp on at last", shared_out, 1);
        wait_cyc(20);
        check("R3 held", pixel_count, 4095);
        check("R9 hblank still off", hblank_out, 0);
        check("R9 clamp still on", shared_out, 1);
        check("R10 overflow on hold", overflow, 1);
        hd_pulse();
        check("R3 released by hd", pixel_count, 0);
        vd_pulse();
        check("R10 cleared again", overflow, 0);

        // R4 R10: line saturation
        for (int k = 0; k < 4095; k++) hd_pulse();
        check("R4 line at last", line_count, 4095);
        check("R10 no line overflow yet", overflow, 0);
        hd_pulse(); hd_pulse();
        check("R4 line saturated", line_count, 4095);
        check("R10 line overflow", overflow, 1);
        vd_pulse();
        check("R5 line cleared after saturation", line_count, 0);
        check("R10 cleared after line overflow", overflow, 0);

        // R11: synchronous reset mid-run
        wait_cyc(7);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R11 pixel after reset", pixel_count, 0);
        check("R11 overflow after reset", overflow, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule